// File: doc/BRIEF.md
# Grouped Message Interrupt Collector

This block collects message signaled interrupts and turns them into a small set of edge-signalled lines for a host interrupt controller. A device raises an interrupt by writing an interrupt number into one message index register. The bus address of that register is the message address. The block has a fixed pool of message numbers, 256 by default. Each number is stored as one pending bit in a bank of pending registers, 32 bits wide and eight of them by default. Each register owns exactly one output line toward the host.

Each output line gives a single-cycle pulse when a fresh source appears in its register. Software then reads the register to see which sources fired, and that read clears what it returned. A per-group enable vector sets which groups are available, in whole 32-number blocks. A group that is not available drops its messages and never drives its line.

Top module: `msi_aggregator`

## Requirements
- R1: After reset every pending register holds zero and every `irq_out` bit is low.
- R2: On a clock edge where `msg_valid` is high, `msg_idx[7:5]` selects the register and `msg_idx[4:0]` selects the bit. When that register's group is enabled, the bit is set and is visible through a read from the next cycle on.
- R3: While `rd_valid` is high, `rd_data` shows the register selected by `rd_sel` in the same cycle, and it shows zero otherwise. The edge that ends the read clears every bit it returned.
- R4: A message that lands on the same edge as a read of its own register stays pending after that edge.
- R5: `irq_out[g]` is high for exactly the one cycle after an edge on which a message set a bit in enabled group g that was not pending after that edge's read clear.
- R6: A message to a bit that is already pending, and not cleared by a read on the same edge, leaves the register unchanged and produces no pulse.
- R7: A message to a group whose `grp_enable` bit is low is dropped and sets no bit. `irq_out[g]` is never high while `grp_enable[g]` is low.
- R8: A message only affects its own register and line, including at the group boundaries (numbers 31, 32 and 255). At most one `irq_out` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | Write strobe for the message index register |
| msg_idx | input | 8 | Interrupt number being written |
| rd_valid | input | 1 | Read strobe for a pending register; clears it at the edge |
| rd_sel | input | 3 | Pending register being read |
| rd_data | output | 32 | Contents of the selected register while reading, else zero |
| grp_enable | input | 8 | One availability bit per 32-number group |
| irq_out | output | 8 | One edge pulse line per pending register |

## Verification
Some properties are checked by assertions on every cycle:
- every pulse comes from a message to that group on the previous edge;
- an enabled message always leaves its bit set;
- a duplicate message never pulses;
- a disabled message never sets a bit;
- at most one line pulses at a time.

Other behaviour only the bench scenarios can show. These are the exact read-back values after mixed traffic, the clearing on read, the reset contents of every register, and the same-edge read-and-message race. The bench compares every pulse and every read against its own model of the pending bank.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    parameter int unsigned MSI_GROUPS  = 8;
    parameter int unsigned MSI_GROUP_W = 32;

    function automatic logic [MSI_GROUPS-1:0] grp_onehot(input logic [$clog2(MSI_GROUPS)-1:0] sel);
        logic [MSI_GROUPS-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/msi_index_decode.sv
module msi_index_decode #(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned GROUP_W    = 32,
    localparam int unsigned SEL_W     = $clog2(NUM_GROUPS),
    localparam int unsigned BIT_W     = $clog2(GROUP_W),
    localparam int unsigned IDX_W     = SEL_W + BIT_W
) (
    input  logic                                  msg_valid,
    input  logic [IDX_W-1:0]                      msg_idx,
    input  logic [NUM_GROUPS-1:0]                 grp_enable,
    output logic [NUM_GROUPS-1:0][GROUP_W-1:0]    set_bits
);
    logic [SEL_W-1:0] grp_sel;
    logic [BIT_W-1:0] bit_sel;

    assign grp_sel = msg_idx[IDX_W-1:BIT_W];
    assign bit_sel = msg_idx[BIT_W-1:0];

    always_comb begin
        set_bits = '0;
        if (msg_valid && grp_enable[grp_sel]) begin
            set_bits[grp_sel][bit_sel] = 1'b1;
        end
    end
endmodule

// File: rtl/msi_group.sv
module msi_group #(
    parameter int unsigned GROUP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] set_bits,
    input  logic               clr,
    output logic [GROUP_W-1:0] pend,
    output logic               pulse
);
    typedef struct packed {
        logic [GROUP_W-1:0] pending;
        logic               pulse;
    } grp_state_t;

    grp_state_t state_d, state_q;
    logic [GROUP_W-1:0] keep_d;
    logic [GROUP_W-1:0] fresh_d;

    always_comb begin
        state_d         = state_q;
        keep_d          = clr ? '0 : state_q.pending;
        fresh_d         = set_bits & ~keep_d;
        state_d.pending = keep_d | set_bits;
        state_d.pulse   = |fresh_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend  = state_q.pending;
    assign pulse = state_q.pulse;
endmodule

// File: rtl/msi_aggregator.sv
module msi_aggregator
    import msi_agg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = MSI_GROUPS,
    parameter int unsigned GROUP_W    = MSI_GROUP_W,
    localparam int unsigned SEL_W     = $clog2(NUM_GROUPS),
    localparam int unsigned BIT_W     = $clog2(GROUP_W),
    localparam int unsigned IDX_W     = SEL_W + BIT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  msg_valid,
    input  logic [IDX_W-1:0]      msg_idx,
    input  logic                  rd_valid,
    input  logic [SEL_W-1:0]      rd_sel,
    output logic [GROUP_W-1:0]    rd_data,
    input  logic [NUM_GROUPS-1:0] grp_enable,
    output logic [NUM_GROUPS-1:0] irq_out
);
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] set_bits;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] pend_bank;
    logic [NUM_GROUPS-1:0]              clr_vec;
    logic [NUM_GROUPS-1:0]              pulse_vec;
    logic [NUM_GROUPS*GROUP_W-1:0]      pend_flat;

    msi_index_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_W    (GROUP_W)
    ) u_decode (
        .msg_valid  (msg_valid),
        .msg_idx    (msg_idx),
        .grp_enable (grp_enable),
        .set_bits   (set_bits)
    );

    assign clr_vec = rd_valid ? grp_onehot(rd_sel) : '0;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        msi_group #(
            .GROUP_W (GROUP_W)
        ) u_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_bits[g]),
            .clr      (clr_vec[g]),
            .pend     (pend_bank[g]),
            .pulse    (pulse_vec[g])
        );
        assign pend_flat[g*GROUP_W +: GROUP_W] = pend_bank[g];
    end

    assign rd_data = rd_valid ? pend_bank[rd_sel] : '0;
    assign irq_out = pulse_vec & grp_enable;
endmodule

// File: rtl/msi_aggregator_chk.sv
module msi_aggregator_chk #(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned GROUP_W    = 32,
    localparam int unsigned SEL_W     = $clog2(NUM_GROUPS),
    localparam int unsigned BIT_W     = $clog2(GROUP_W),
    localparam int unsigned IDX_W     = SEL_W + BIT_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          msg_valid,
    input logic [IDX_W-1:0]              msg_idx,
    input logic                          rd_valid,
    input logic [SEL_W-1:0]              rd_sel,
    input logic [NUM_GROUPS-1:0]         grp_enable,
    input logic [NUM_GROUPS-1:0]         irq_out,
    input logic [NUM_GROUPS*GROUP_W-1:0] pend_flat
);
    logic [SEL_W-1:0] msg_grp;
    assign msg_grp = msg_idx[IDX_W-1:BIT_W];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_src
        // R5: a pulse traces back to a message for this group on the previous edge
        assert_pulse_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[g] |-> ($past(msg_valid) && ($past(msg_grp) == SEL_W'(g))));
    end

    assert_enabled_msg_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && grp_enable[msg_grp]) |=> pend_flat[$past(msg_idx)]);

    assert_duplicate_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && pend_flat[msg_idx] && !(rd_valid && (rd_sel == msg_grp)))
        |=> (irq_out == '0));

    assert_disabled_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !grp_enable[msg_grp] && !pend_flat[msg_idx])
        |=> !pend_flat[$past(msg_idx)]);

    assert_single_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out));
endmodule

bind msi_aggregator msi_aggregator_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_idx    (msg_idx),
    .rd_valid   (rd_valid),
    .rd_sel     (rd_sel),
    .grp_enable (grp_enable),
    .irq_out    (irq_out),
    .pend_flat  (pend_flat)
);

// File: tb/msi_aggregator_tb.sv
`timescale 1ns/1ps
module msi_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_idx = '0;
    logic        rd_valid = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [7:0]  grp_enable = '0;
    logic [7:0]  irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_pend [8];
    logic [7:0]  exp_irq;

    always #2 clk = ~clk;

    msi_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_idx(msg_idx),
        .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_data(rd_data),
        .grp_enable(grp_enable), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] f_pulse(input logic mv, input logic [7:0] idx,
                                           input logic rv, input logic [2:0] sel,
                                           input logic [7:0] en);
        logic [7:0] r;
        logic       kept;
        r = '0;
        if (mv && en[idx[7:5]]) begin
            kept = (rv && sel == idx[7:5]) ? 1'b0 : exp_pend[idx[7:5]][idx[4:0]];
            if (!kept) r[idx[7:5]] = 1'b1;
        end
        return r & en;
    endfunction

    task automatic step(input string tag, input logic mv, input logic [7:0] idx,
                        input logic rv, input logic [2:0] sel, input logic [7:0] en);
        @(negedge clk);
        chk({tag, " irq"}, {24'd0, irq_out}, {24'd0, exp_irq});
        msg_valid = mv; msg_idx = idx; rd_valid = rv; rd_sel = sel; grp_enable = en;
        #1;
        chk({tag, " rd"}, rd_data, rv ? exp_pend[sel] : 32'd0);
        exp_irq = f_pulse(mv, idx, rv, sel, en);
        if (rv) exp_pend[sel] = '0;
        if (mv && en[idx[7:5]]) exp_pend[idx[7:5]][idx[4:0]] = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) exp_pend[i] = '0;
        exp_irq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq at reset", {24'd0, irq_out}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step("R1", 1'b0, 8'd0, 1'b1, 3'(i), 8'hFF);

        // R2 decode: number 0x25 is register 1 bit 5
        step("R2", 1'b1, 8'h25, 1'b0, 3'd0, 8'hFF);
        step("R5", 1'b0, 8'h00, 1'b0, 3'd0, 8'hFF);
        chk("R2 model", exp_pend[1], 32'h0000_0020);
        // R6 duplicate gives no pulse
        step("R6", 1'b1, 8'h25, 1'b0, 3'd0, 8'hFF);
        step("R6", 1'b0, 8'h00, 1'b1, 3'd1, 8'hFF);
        step("R3", 1'b0, 8'h00, 1'b1, 3'd1, 8'hFF);
        // R4 message on same edge as read
        step("R4", 1'b1, 8'h41, 1'b0, 3'd0, 8'hFF);
        step("R4", 1'b1, 8'h47, 1'b1, 3'd2, 8'hFF);
        step("R4", 1'b0, 8'h00, 1'b1, 3'd2, 8'hFF);
        chk("R4 model", exp_pend[2], 32'd0);
        // R7 disabled group drops messages
        step("R7", 1'b1, 8'h03, 1'b0, 3'd0, 8'hFE);
        step("R7", 1'b0, 8'h00, 1'b1, 3'd0, 8'hFE);
        step("R7", 1'b1, 8'hE0, 1'b0, 3'd0, 8'h7F);
        step("R7", 1'b0, 8'h00, 1'b1, 3'd7, 8'h7F);
        // R8 group boundaries
        step("R8", 1'b1, 8'd31, 1'b0, 3'd0, 8'hFF);
        step("R8", 1'b1, 8'd32, 1'b0, 3'd0, 8'hFF);
        step("R8", 1'b1, 8'd255, 1'b0, 3'd0, 8'hFF);
        step("R8", 1'b0, 8'h00, 1'b1, 3'd0, 8'hFF);
        step("R8", 1'b0, 8'h00, 1'b1, 3'd1, 8'hFF);
        step("R8", 1'b0, 8'h00, 1'b1, 3'd7, 8'hFF);

        // R5 mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] en;
            en = ($urandom % 8 == 0) ? 8'($urandom) : 8'hFF;
            step("R5", ($urandom % 2) == 0, 8'($urandom), ($urandom % 4) == 0,
                 3'($urandom), en);
        end
        for (int i = 0; i < 8; i++) step("R3", 1'b0, 8'd0, 1'b1, 3'(i), 8'hFF);
        step("R5", 1'b0, 8'd0, 1'b0, 3'd0, 8'hFF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule